// File: doc/BRIEF.md
# Four-Quadrant H-Bridge PWM Generator

This block drives the four switches of a full H-bridge from a single signed control word. The bridge runs in four-quadrant mode. One diagonal pair (left high side with right low side) conducts while the period counter is below the duty value. The opposite diagonal (right high side with left low side) conducts for the rest of the period. The control word is shifted by half the period, so a control word of zero gives a 50% duty cycle and zero average motor voltage. Positive words push the motor one way and negative words push it the other way.

Every switch turn-on waits for a deadband measured in clock cycles. Every turn-off takes effect at once. This gives both legs time to commutate without shoot-through. A current-limit input removes all drive in the cycle it is seen, and the drive stays off until the period counter wraps. The duty value is sampled once per period, at the wrap, so a control update never cuts a period short.

Top module: `hbridge_pwm`

## Requirements
- R1: left_hi always equals right_lo (diagonal pair A), and right_hi always equals left_lo (diagonal pair B). Outside deadband and current-limit intervals, pair B is the inverse of pair A.
- R2: A control word of 0 produces a duty value of PERIOD/2, so pair A is requested for exactly half of each period.
- R3: The duty value is ctrl + PERIOD/2. It is loaded only in the cycle where the period counter wraps from PERIOD-1 to 0. During the following period, pair A is requested while the counter is below the duty value, and pair B is requested otherwise.
- R4: The duty value is clamped to the range 0..PERIOD. A value of 0 never requests pair A, and a value of PERIOD never requests pair B.
- R5: A pair turns on only after it has been requested for DEAD consecutive cycles. It turns off in the same cycle its request is dropped. A request shorter than DEAD cycles never turns the pair on.
- R6: When ilim is high, both pairs are off in that same cycle. They stay off until the counter wraps to 0, and they are off for the whole of any cycle in which ilim is high.
- R7: After a synchronous active-low reset, all four outputs are low, the counter is 0 and the duty value is PERIOD/2.
- R8: Pair A and pair B are never on in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctrl | input | CTRL_W | Signed control word (two's complement) |
| ilim | input | 1 | Over-current indication, active high |
| left_hi | output | 1 | Left leg high-side switch (pair A) |
| left_lo | output | 1 | Left leg low-side switch (pair B) |
| right_hi | output | 1 | Right leg high-side switch (pair B) |
| right_lo | output | 1 | Right leg low-side switch (pair A) |

## Verification
The current limit and the period wrap can land in the same cycle. The bench provokes this by raising ilim exactly when the counter holds PERIOD-1, and again when it holds 0. It then checks that the limit clears at the wrap yet still blanks its own cycle. A deadband turn-on can also coincide with the limit or with the wrap, when the duty value is 0 or PERIOD and one pair's request carries across the boundary. Each cycle's four outputs are compared against a reference model that is built from the requirements alone.

// File: rtl/hbpwm_pkg.sv
// Shared definitions for the H-bridge PWM generator.
// Assumes: pair index 0 is the diagonal left_hi/right_lo, index 1 is right_hi/left_lo.
package hbpwm_pkg;
    localparam int PAIR_A = 0;
    localparam int PAIR_B = 1;
    localparam int NPAIRS = 2;

    typedef logic [NPAIRS-1:0] pair_vec_t;
endpackage

// File: rtl/hbpwm_duty_map.sv
// Maps a signed control word to an unsigned compare value: ctrl + PERIOD/2,
// clamped to 0..PERIOD. Purely combinational.
// Assumes: PERIOD >= 2, CNT_W wide enough to hold PERIOD.
module hbpwm_duty_map #(
    parameter int PERIOD = 10000,
    parameter int CTRL_W = 16,
    parameter int CNT_W  = $clog2(PERIOD + 1)
) (
    input  logic signed [CTRL_W-1:0] ctrl_i,
    output logic        [CNT_W-1:0]  duty_o
);
    localparam int SW = (CTRL_W > CNT_W ? CTRL_W : CNT_W) + 2;

    logic signed [SW-1:0] sum;

    // Offset the signed word by half the period and clamp to the legal range.
    always_comb begin
        sum = SW'(ctrl_i) + SW'(PERIOD / 2);
        if (sum < 0)
            duty_o = '0;
        else if (sum > SW'(PERIOD))
            duty_o = CNT_W'(PERIOD);
        else
            duty_o = sum[CNT_W-1:0];
    end
endmodule

// File: rtl/hbpwm_core.sv
// Period counter with a shadow duty register. The duty value is captured
// only at the wrap, and the raw pair-A request is high while count < duty.
// Assumes: duty_next_i is already clamped to 0..PERIOD.
module hbpwm_core #(
    parameter int PERIOD = 10000,
    parameter int CNT_W  = $clog2(PERIOD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] duty_next_i,
    output logic             wrap_o,
    output logic             raw_a_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] duty_q;

    assign wrap_o  = (cnt_q == CNT_W'(PERIOD - 1));
    assign raw_a_o = (cnt_q < duty_q);

    // Free-running period counter, 0 .. PERIOD-1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (wrap_o)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // Shadow duty register, updated only on the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            duty_q <= CNT_W'(PERIOD / 2);
        else if (wrap_o)
            duty_q <= duty_next_i;
    end

    // R3
    duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_o |=> $stable(duty_q));
    // R4
    duty_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        duty_q <= CNT_W'(PERIOD));
endmodule

// File: rtl/hbpwm_deadband.sv
// Turn-on delay for one diagonal pair. The output rises only after the
// request has been held for DEAD cycles, and it falls in the same cycle the
// request drops. Assumes: DEAD >= 0.
module hbpwm_deadband #(
    parameter int DEAD = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want_i,
    output logic on_o
);
    localparam int DW = $clog2(DEAD + 2);

    logic [DW-1:0] dly_q;

    // Count consecutive request cycles, saturating at DEAD.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dly_q <= '0;
        else if (!want_i)
            dly_q <= '0;
        else if (dly_q != DW'(DEAD))
            dly_q <= dly_q + 1'b1;
    end

    assign on_o = want_i && (dly_q == DW'(DEAD));

    // R5
    on_needs_history_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (DEAD > 0 && $rose(on_o)) |-> $past(want_i));
    // R5
    fresh_request_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (DEAD > 0 && $rose(want_i)) |-> !on_o);
endmodule

// File: rtl/hbridge_pwm.sv
// Four-quadrant H-bridge PWM top. It maps the control word to a duty value,
// runs the period counter, applies the cycle-by-cycle current limit and
// delays each pair's turn-on. Assumes: ilim is already synchronous to clk.
module hbridge_pwm #(
    parameter int PERIOD = 10000,
    parameter int DEAD   = 400,
    parameter int CTRL_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [CTRL_W-1:0] ctrl,
    input  logic                     ilim,
    output logic                     left_hi,
    output logic                     left_lo,
    output logic                     right_hi,
    output logic                     right_lo
);
    import hbpwm_pkg::*;

    localparam int CNT_W = $clog2(PERIOD + 1);

    logic [CNT_W-1:0] duty_next;
    logic             wrap;
    logic             raw_a;
    logic             lim_q;
    logic             blank;
    pair_vec_t        want;
    pair_vec_t        on;

    hbpwm_duty_map #(.PERIOD(PERIOD), .CTRL_W(CTRL_W), .CNT_W(CNT_W)) u_map (
        .ctrl_i (ctrl),
        .duty_o (duty_next)
    );

    hbpwm_core #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .duty_next_i (duty_next),
        .wrap_o      (wrap),
        .raw_a_o     (raw_a)
    );

    // Current-limit latch: set by ilim, cleared at the period wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lim_q <= 1'b0;
        else if (wrap)
            lim_q <= 1'b0;
        else if (ilim)
            lim_q <= 1'b1;
    end

    // Pair requests, blanked by the live or latched current limit.
    always_comb begin
        blank        = lim_q | ilim;
        want[PAIR_A] = raw_a & ~blank;
        want[PAIR_B] = ~raw_a & ~blank;
    end

    for (genvar g = 0; g < NPAIRS; g++) begin : g_pair
        hbpwm_deadband #(.DEAD(DEAD)) u_dead (
            .clk    (clk),
            .rst_n  (rst_n),
            .want_i (want[g]),
            .on_o   (on[g])
        );
    end

    assign left_hi  = on[PAIR_A];
    assign right_lo = on[PAIR_A];
    assign right_hi = on[PAIR_B];
    assign left_lo  = on[PAIR_B];

    // R8
    no_shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(left_hi && right_hi) && !(left_lo && right_lo));
    // R6
    limit_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_q || ilim) |-> !(left_hi || right_hi));
    // R6
    limit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ilim && !wrap) |=> lim_q);
endmodule

// File: tb/test_hbridge_pwm.sv
// Scoreboard bench: the driver task steps a reference model built from the
// requirements and queues the expected outputs; the monitor compares them.
module test_hbridge_pwm;
    localparam int P  = 20;
    localparam int DL = 3;
    localparam int CW = 8;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic signed [CW-1:0] ctrl = '0;
    logic                 ilim = 1'b0;
    logic                 left_hi, left_lo, right_hi, right_lo;

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    int n_chk  = 0;
    int n_fail = 0;

    // Reference model state.
    int mcnt, mduty, mda, mdb;
    bit mlim;

    always #2.5 clk = ~clk;

    hbridge_pwm #(.PERIOD(P), .DEAD(DL), .CTRL_W(CW)) i_hbridge_pwm (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .ilim(ilim),
        .left_hi(left_hi), .left_lo(left_lo),
        .right_hi(right_hi), .right_lo(right_lo)
    );

    // Monitor: compare each queued expectation just after the falling edge.
    always @(negedge clk) begin
        #1;
        while (q.size() > 0) begin
            item_t it;
            logic [3:0] act;
            it  = q.pop_front();
            act = {left_hi, left_lo, right_hi, right_lo};
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: {lh,ll,rh,rl} actual %b expected %b at %0t",
                         it.tag, act, it.exp, $time);
            end
        end
    end

    // Driver: apply one control word for n cycles, pulsing ilim when the
    // model counter equals lim_at (-1 disables the pulse).
    task automatic run(input int c, input int n, input int lim_at, input string tag);
        for (int i = 0; i < n; i++) begin
            bit raw, wa, wb, oa, ob, lim_now;
            int d;
            ctrl    = CW'(c);
            lim_now = (lim_at >= 0) && (mcnt == lim_at);
            ilim    = lim_now;
            raw = (mcnt < mduty);
            wa  = raw && !mlim && !lim_now;
            wb  = !raw && !mlim && !lim_now;
            oa  = wa && (mda == DL);
            ob  = wb && (mdb == DL);
            q.push_back('{exp: {oa, ob, ob, oa}, tag: tag});
            // advance the model to the next cycle
            if (mcnt == P - 1) begin
                d = c + P / 2;
                if (d < 0) d = 0;
                if (d > P) d = P;
                mduty = d;
                mlim  = 0;
                mcnt  = 0;
            end else begin
                mcnt++;
                if (lim_now) mlim = 1;
            end
            mda = wa ? ((mda < DL) ? mda + 1 : DL) : 0;
            mdb = wb ? ((mdb < DL) ? mdb + 1 : DL) : 0;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R7: outputs low while reset is held
        n_chk++;
        if ({left_hi, left_lo, right_hi, right_lo} !== 4'b0000) begin
            n_fail++;
            $display("FAIL R7: {lh,ll,rh,rl} actual %b expected 0000",
                     {left_hi, left_lo, right_hi, right_lo});
        end
        mcnt = 0; mduty = P / 2; mda = 0; mdb = 0; mlim = 0;
        rst_n = 1'b1;
        run(0,    2 * P, -1, "R7 R2 R1 zero command half duty");
        run(5,    2 * P, -1, "R3 positive command");
        run(-7,   2 * P, -1, "R3 negative command");
        run(100,  2 * P, -1, "R4 clamp high");
        run(-100, 2 * P, -1, "R4 clamp low");
        run(8,    2 * P, -1, "R5 short pair-B request");
        run(-8,   2 * P, -1, "R5 short pair-A request");
        run(0,    2 * P,  5, "R6 limit in pair-A phase");
        run(0,    2 * P, 14, "R6 limit in pair-B phase");
        run(0,    2 * P, P - 1, "R6 limit at wrap");
        run(0,    2 * P,  0, "R6 limit at period start");
        run(10,   2 * P,  7, "R6 R8 limit with full duty");
        run(3,    2 * P, -1, "R1 R8 recovery");
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule